// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for one display channel: horizontal and vertical sync, a data-enable window, a field flag for interlaced scan, a one-cycle frame-start marker, and the pixel and line coordinates inside the active window. It runs on the pixel clock. Its settings come in as plain configuration inputs. The horizontal and vertical back-porch settings are measured from the leading edge of sync, so each one already includes the sync width.

The channel select picks between a primary panel channel and a secondary TV-style channel. On the secondary channel a progressive mode gives its vertical total in half-lines, which is twice the line count. An interlaced mode, on either channel, gives the undoubled frame total and shows half the frame's active lines in each field. The block also derives a start-of-active delay value from vertical blanking.

All outputs are held undriven until the channel is enabled. A new mode is taken up only at a field boundary, so a line is never split between two modes.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset, `pad_oe`, `hsync_o`, `vsync_o`, `de_o`, `field_o` and `frame_start_o` are 0, and `pix_x`, `pix_y` and `start_delay` are 0.
- R2: While running, the horizontal count steps 0, 1, …, `h_total`-1 and then wraps. The raw horizontal sync is active while the count is below `h_sync`.
- R3: The number of lines in each field depends on the mode. Primary progressive: `v_total`. Secondary progressive: `v_total`/2, because that total is in half-lines. Interlaced: `v_total`/2 (rounded down) in field 0 and the remaining lines in field 1. The raw vertical sync is active while the line count is below `v_sync`.
- R4: `de_o` is 1 only when the horizontal count is in [`h_bp`, `h_bp`+`h_active`) and the line count is in [`v_bp`, `v_bp`+A). A is `v_active`, or `v_active`/2 when interlaced. While `de_o` is 1, `pix_x` = horizontal count − `h_bp` and `pix_y` = line count − `v_bp`. Both coordinates are 0 otherwise.
- R5: At each field wrap, `field_o` toggles when the mode being loaded is interlaced and is cleared otherwise. It is 0 in every progressive field.
- R6: `frame_start_o` is 1 for exactly the cycles in which both counts are 0, which is the first cycle of every field.
- R7: `hsync_o` = raw hsync XOR (`cfg_hs_inv` AND NOT `cfg_force_high`), and `vsync_o` is formed the same way from `cfg_vs_inv`. Both use the mode currently in effect.
- R8: `pad_oe` is 0 while the channel is disabled. One cycle after `cfg_enable` is first seen high, `pad_oe` is 1, the mode is loaded and both counts are 0. One cycle after `cfg_enable` goes low, `pad_oe` is 0 and the counts are cleared.
- R9: Configuration changes made during a field take effect only at the next field wrap or at a fresh enable.
- R10: `start_delay` is computed in four steps. First, take B = (`v_total`/2 on secondary progressive, else `v_total`) − `v_active`, floored at 0. Second, halve B when interlaced. Third, subtract 2 on the secondary channel, floored at 0. Fourth, saturate at 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_chan | input | 1 | 0 = primary channel, 1 = secondary channel |
| cfg_interlace | input | 1 | Interlaced scan |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_total | input | HW | Pixels per line |
| cfg_h_bp | input | HW | Sync plus back porch, in pixels |
| cfg_h_sync | input | HW | Horizontal sync width |
| cfg_v_active | input | VW | Active lines per frame |
| cfg_v_total | input | VW | Vertical total (half-lines on secondary progressive) |
| cfg_v_bp | input | VW | Sync plus back porch, in lines |
| cfg_v_sync | input | VW | Vertical sync width in lines |
| cfg_hs_inv | input | 1 | Invert horizontal sync |
| cfg_vs_inv | input | 1 | Invert vertical sync |
| cfg_force_high | input | 1 | Ignore both inversion bits |
| pad_oe | output | 1 | Output drive enable (0 = tristate) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Current field |
| frame_start_o | output | 1 | First cycle of a field |
| pix_x | output | HW | Pixel index in active window |
| pix_y | output | VW | Line index in active window |
| start_delay | output | 5 | Derived start-of-active delay |

## Verification
The assertions take some things about the mode for granted:
- `h_total` is at least 1, and each field has at least one line.
- Each sync width is no larger than its back-porch setting.
- Back porch plus active fits inside the total in both directions.

Under those conditions, data-enable lies inside the driven period, `pix_x` stays below the active width, and the field and shadowed mode change only on frame-start cycles.

The random stimulus builds each mode from separate active, sync, porch and front-porch amounts and sums them, so the conditions hold. The total is doubled only for secondary progressive modes. Directed cases use large vertical totals that only exercise the delay derivation, and each of them is disabled well before its first line wrap.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int DELAY_MAX = 30;
  localparam int DELAY_W   = $clog2(DELAY_MAX + 1);

  typedef enum logic {
    CH_PRIMARY   = 1'b0,
    CH_SECONDARY = 1'b1
  } chan_e;
endpackage

// File: rtl/lcd_tg_hcount.sv
module lcd_tg_hcount #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,      // counting allowed this cycle
  input  logic          act,      // channel running (decode qualifier)
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_sync,
  input  logic [HW-1:0] h_bp,
  input  logic [HW-1:0] h_active,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic          hs_act,
  output logic          h_win
);
  logic [HW:0]   hnext;
  logic [HW:0]   win_end;
  logic [HW-1:0] hcnt_n;

  assign hnext    = {1'b0, hcnt} + 1'b1;
  assign win_end  = {1'b0, h_bp} + {1'b0, h_active};
  assign line_end = adv && (hnext >= {1'b0, h_total});
  assign hs_act   = act && (hcnt < h_sync);
  assign h_win    = act && (hcnt >= h_bp) && ({1'b0, hcnt} < win_end);

  always_comb begin
    if (!adv)          hcnt_n = '0;
    else if (line_end) hcnt_n = '0;
    else               hcnt_n = hnext[HW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= '0;
    else        hcnt <= hcnt_n;
  end
endmodule

// File: rtl/lcd_tg_vcount.sv
module lcd_tg_vcount
  import lcd_tg_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          act,
  input  logic          line_end,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] v_bp,
  input  logic [VW-1:0] v_sync,
  input  logic          interlace,
  input  chan_e         chan,
  input  logic          nxt_interlace, // mode loaded at the wrap
  output logic [VW-1:0] vcnt,
  output logic          field,
  output logic          field_end,
  output logic          vs_act,
  output logic          v_win
);
  logic [VW-1:0] vlines;
  logic [VW-1:0] vact;
  logic [VW:0]   vnext;
  logic [VW:0]   win_end;
  logic [VW-1:0] vcnt_n;
  logic          field_n;

  always_comb begin
    if (interlace)                 vlines = field ? (v_total - (v_total >> 1)) : (v_total >> 1);
    else if (chan == CH_SECONDARY) vlines = v_total >> 1;
    else                           vlines = v_total;
  end

  assign vact      = interlace ? (v_active >> 1) : v_active;
  assign vnext     = {1'b0, vcnt} + 1'b1;
  assign win_end   = {1'b0, v_bp} + {1'b0, vact};
  assign field_end = line_end && (vnext >= {1'b0, vlines});
  assign vs_act    = act && (vcnt < v_sync);
  assign v_win     = act && (vcnt >= v_bp) && ({1'b0, vcnt} < win_end);

  always_comb begin
    vcnt_n  = vcnt;
    field_n = field;
    if (!adv) begin
      vcnt_n  = '0;
      field_n = 1'b0;
    end else if (field_end) begin
      vcnt_n  = '0;
      field_n = nxt_interlace & ~field;
    end else if (line_end) begin
      vcnt_n  = vnext[VW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt  <= '0;
      field <= 1'b0;
    end else begin
      vcnt  <= vcnt_n;
      field <= field_n;
    end
  end
endmodule

// File: rtl/lcd_tg_delay.sv
module lcd_tg_delay
  import lcd_tg_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic [VW-1:0]      v_total,
  input  logic [VW-1:0]      v_active,
  input  logic               interlace,
  input  chan_e              chan,
  output logic [DELAY_W-1:0] delay
);
  logic [VW-1:0] base;
  logic [VW-1:0] blank;
  logic [VW-1:0] half;
  logic [VW-1:0] trim;

  always_comb begin
    base  = (chan == CH_SECONDARY && !interlace) ? (v_total >> 1) : v_total;
    blank = (base > v_active) ? (base - v_active) : '0;
    half  = interlace ? (blank >> 1) : blank;
    if (chan == CH_SECONDARY) trim = (half > VW'(2)) ? (half - VW'(2)) : '0;
    else                      trim = half;
    delay = (trim > VW'(DELAY_MAX)) ? DELAY_W'(DELAY_MAX) : trim[DELAY_W-1:0];
  end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_tg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_chan,
  input  logic               cfg_interlace,
  input  logic [HW-1:0]      cfg_h_active,
  input  logic [HW-1:0]      cfg_h_total,
  input  logic [HW-1:0]      cfg_h_bp,
  input  logic [HW-1:0]      cfg_h_sync,
  input  logic [VW-1:0]      cfg_v_active,
  input  logic [VW-1:0]      cfg_v_total,
  input  logic [VW-1:0]      cfg_v_bp,
  input  logic [VW-1:0]      cfg_v_sync,
  input  logic               cfg_hs_inv,
  input  logic               cfg_vs_inv,
  input  logic               cfg_force_high,
  output logic               pad_oe,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               field_o,
  output logic               frame_start_o,
  output logic [HW-1:0]      pix_x,
  output logic [VW-1:0]      pix_y,
  output logic [DELAY_W-1:0] start_delay
);
  typedef struct packed {
    logic [HW-1:0] h_active;
    logic [HW-1:0] h_total;
    logic [HW-1:0] h_bp;
    logic [HW-1:0] h_sync;
    logic [VW-1:0] v_active;
    logic [VW-1:0] v_total;
    logic [VW-1:0] v_bp;
    logic [VW-1:0] v_sync;
    logic          il;
    chan_e         chan;
    logic          hs_inv;
    logic          vs_inv;
    logic          force_high;
  } mode_t;

  mode_t         sh, sh_n, cfg_now;
  logic          running, running_n;
  logic          start, load, adv;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end, field_end, hs_act, vs_act, h_win, v_win, field;
  logic          de_int;

  always_comb begin
    cfg_now.h_active   = cfg_h_active;
    cfg_now.h_total    = cfg_h_total;
    cfg_now.h_bp       = cfg_h_bp;
    cfg_now.h_sync     = cfg_h_sync;
    cfg_now.v_active   = cfg_v_active;
    cfg_now.v_total    = cfg_v_total;
    cfg_now.v_bp       = cfg_v_bp;
    cfg_now.v_sync     = cfg_v_sync;
    cfg_now.il         = cfg_interlace;
    cfg_now.chan       = chan_e'(cfg_chan);
    cfg_now.hs_inv     = cfg_hs_inv;
    cfg_now.vs_inv     = cfg_vs_inv;
    cfg_now.force_high = cfg_force_high;
  end

  // Next-state: run flag and mode shadow (clock enable = load)
  assign start     = cfg_enable & ~running;
  assign adv       = cfg_enable & running;
  assign load      = start | field_end;
  assign running_n = cfg_enable;
  assign sh_n      = load ? cfg_now : sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sh      <= '0;
    end else begin
      running <= running_n;
      sh      <= sh_n;
    end
  end

  lcd_tg_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .adv(adv), .act(running),
    .h_total(sh.h_total), .h_sync(sh.h_sync), .h_bp(sh.h_bp), .h_active(sh.h_active),
    .hcnt(hcnt), .line_end(line_end), .hs_act(hs_act), .h_win(h_win)
  );

  lcd_tg_vcount #(.VW(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .adv(adv), .act(running), .line_end(line_end),
    .v_total(sh.v_total), .v_active(sh.v_active), .v_bp(sh.v_bp), .v_sync(sh.v_sync),
    .interlace(sh.il), .chan(sh.chan), .nxt_interlace(cfg_interlace),
    .vcnt(vcnt), .field(field), .field_end(field_end), .vs_act(vs_act), .v_win(v_win)
  );

  lcd_tg_delay #(.VW(VW)) u_d (
    .v_total(sh.v_total), .v_active(sh.v_active), .interlace(sh.il), .chan(sh.chan),
    .delay(start_delay)
  );

  // Output decode
  assign de_int        = h_win & v_win;
  assign pad_oe        = running;
  assign hsync_o       = hs_act ^ (sh.hs_inv & ~sh.force_high);
  assign vsync_o       = vs_act ^ (sh.vs_inv & ~sh.force_high);
  assign de_o          = de_int;
  assign field_o       = field;
  assign frame_start_o = running && (hcnt == '0) && (vcnt == '0);
  assign pix_x         = de_int ? (hcnt - sh.h_bp) : '0;
  assign pix_y         = de_int ? (vcnt - sh.v_bp) : '0;
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk
  import lcd_tg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_enable,
  input logic               pad_oe,
  input logic               de_o,
  input logic               field_o,
  input logic               frame_start_o,
  input logic [HW-1:0]      pix_x,
  input logic [HW-1:0]      sh_h_active,
  input logic [HW-1:0]      sh_h_total,
  input logic               sh_il,
  input logic [DELAY_W-1:0] start_delay
);
  AST_OE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !pad_oe); // R8
  AST_START_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_oe) |-> frame_start_o); // R6
  AST_DE_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> pad_oe); // R4
  AST_X_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (pix_x < sh_h_active)); // R4
  AST_FIELD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(pad_oe) && !frame_start_o) |-> $stable(field_o)); // R5
  AST_FIELD_PROGRESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_il |-> !field_o); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(pad_oe) && !frame_start_o) |-> $stable(sh_h_total)); // R9
  AST_DELAY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    start_delay <= DELAY_W'(DELAY_MAX)); // R10
endmodule

bind lcd_raster_gen lcd_tg_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .pad_oe(pad_oe),
  .de_o(de_o), .field_o(field_o), .frame_start_o(frame_start_o), .pix_x(pix_x),
  .sh_h_active(sh.h_active), .sh_h_total(sh.h_total), .sh_il(sh.il),
  .start_delay(start_delay)
);

// File: tb/tb_lcd_raster_gen.sv
module tb_lcd_raster_gen;
  localparam int HW = 12;
  localparam int VW = 12;
  localparam int HALF_PS = 2500; // 200 MHz, time unit taken as 1 ps

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_enable, cfg_chan, cfg_interlace, cfg_hs_inv, cfg_vs_inv, cfg_force_high;
  logic [HW-1:0] cfg_h_active, cfg_h_total, cfg_h_bp, cfg_h_sync;
  logic [VW-1:0] cfg_v_active, cfg_v_total, cfg_v_bp, cfg_v_sync;
  logic pad_oe, hsync_o, vsync_o, de_o, field_o, frame_start_o;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;
  logic [4:0] start_delay;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 0;
  bit done = 0;

  lcd_raster_gen #(.HW(HW), .VW(VW)) dut (.*);

  always #(HALF_PS) clk = ~clk;

  // ---------------- reference model ----------------
  int m_run, m_h, m_v, m_f;
  int s_ha, s_ht, s_hb, s_hs, s_va, s_vt, s_vb, s_vs, s_il, s_ch, s_hi, s_vi, s_fh;

  function automatic int f_lines(int tot, int il, int ch, int fld);
    if (il != 0) return (fld != 0) ? tot - tot / 2 : tot / 2;
    if (ch != 0) return tot / 2;
    return tot;
  endfunction

  function automatic int f_delay(int tot, int act, int il, int ch);
    int b;
    b = ((ch != 0 && il == 0) ? tot / 2 : tot) - act;
    if (b < 0) b = 0;
    if (il != 0) b = b / 2;
    if (ch != 0) b = (b > 2) ? b - 2 : 0;
    return (b > 30) ? 30 : b;
  endfunction

  task automatic load_shadow();
    s_ha <= cfg_h_active; s_ht <= cfg_h_total; s_hb <= cfg_h_bp; s_hs <= cfg_h_sync;
    s_va <= cfg_v_active; s_vt <= cfg_v_total; s_vb <= cfg_v_bp; s_vs <= cfg_v_sync;
    s_il <= cfg_interlace; s_ch <= cfg_chan; s_hi <= cfg_hs_inv; s_vi <= cfg_vs_inv;
    s_fh <= cfg_force_high;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_h <= 0; m_v <= 0; m_f <= 0;
      s_ha <= 0; s_ht <= 0; s_hb <= 0; s_hs <= 0; s_va <= 0; s_vt <= 0; s_vb <= 0;
      s_vs <= 0; s_il <= 0; s_ch <= 0; s_hi <= 0; s_vi <= 0; s_fh <= 0;
    end else if (!cfg_enable) begin
      m_run <= 0; m_h <= 0; m_v <= 0; m_f <= 0;
    end else if (m_run == 0) begin
      m_run <= 1; m_h <= 0; m_v <= 0; m_f <= 0;
      load_shadow();
    end else if (m_h + 1 >= s_ht) begin
      m_h <= 0;
      if (m_v + 1 >= f_lines(s_vt, s_il, s_ch, m_f)) begin
        m_v <= 0;
        m_f <= cfg_interlace ? 1 - m_f : 0;
        load_shadow();
      end else m_v <= m_v + 1;
    end else m_h <= m_h + 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cmp_on && rst_n) begin
      int vact, de, hs, vs;
      vact = (s_il != 0) ? s_va / 2 : s_va;
      de = (m_run != 0 && m_h >= s_hb && m_h < s_hb + s_ha && m_v >= s_vb && m_v < s_vb + vact) ? 1 : 0;
      hs = ((m_run != 0 && m_h < s_hs) ? 1 : 0) ^ ((s_hi != 0 && s_fh == 0) ? 1 : 0);
      vs = ((m_run != 0 && m_v < s_vs) ? 1 : 0) ^ ((s_vi != 0 && s_fh == 0) ? 1 : 0);
      chk("R8", "pad_oe", int'(pad_oe), m_run);
      chk("R2/R7", "hsync", int'(hsync_o), hs);
      chk("R3/R7", "vsync", int'(vsync_o), vs);
      chk("R4", "de", int'(de_o), de);
      chk("R5", "field", int'(field_o), m_f);
      chk("R6", "frame_start", int'(frame_start_o), (m_run != 0 && m_h == 0 && m_v == 0) ? 1 : 0);
      chk("R4", "pix_x", int'(pix_x), de ? m_h - s_hb : 0);
      chk("R4", "pix_y", int'(pix_y), de ? m_v - s_vb : 0);
      chk("R10", "start_delay", int'(start_delay), f_delay(s_vt, s_va, s_il, s_ch));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_mode(int ch, int il, int ha, int hs, int hb, int hfp,
                          int va, int vs, int vb, int vfp);
    int lines;
    lines = va + vb + vfp;
    cfg_chan = ch[0]; cfg_interlace = il[0];
    cfg_h_active = HW'(ha); cfg_h_sync = HW'(hs); cfg_h_bp = HW'(hb);
    cfg_h_total = HW'(ha + hb + hfp);
    cfg_v_active = VW'(va); cfg_v_sync = VW'(vs); cfg_v_bp = VW'(vb);
    cfg_v_total = VW'((ch != 0 && il == 0) ? 2 * lines : lines);
  endtask

  task automatic rand_mode();
    int hs, vs, il;
    hs = 1 + $urandom % 3;
    vs = 1 + $urandom % 2;
    il = $urandom % 2;
    set_mode($urandom % 2, il, 2 + $urandom % 6, hs, hs + $urandom % 3, 1 + $urandom % 3,
             2 + $urandom % 5, vs, vs + $urandom % 2, il + $urandom % 3);
    cfg_hs_inv = 1'($urandom % 2); cfg_vs_inv = 1'($urandom % 2);
    cfg_force_high = 1'(($urandom % 4) == 0);
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start_o);
  endtask

  task automatic de_run(output int n);
    do @(negedge clk); while (!de_o);
    n = 0;
    while (de_o) begin n++; @(negedge clk); end
  endtask

  task automatic delay_case(int ch, int il, int vt, int va, int exp);
    @(negedge clk);
    cfg_enable = 0;
    @(negedge clk);
    cfg_chan = ch[0]; cfg_interlace = il[0]; cfg_v_total = VW'(vt); cfg_v_active = VW'(va);
    cfg_v_bp = 1; cfg_v_sync = 1;
    cfg_enable = 1;
    @(negedge clk);
    chk("R10", "start_delay directed", int'(start_delay), exp);
    @(negedge clk);
    cfg_enable = 0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    rst_n = 0;
    cfg_enable = 0; cfg_hs_inv = 0; cfg_vs_inv = 0; cfg_force_high = 0;
    set_mode(0, 0, 4, 1, 2, 2, 3, 1, 1, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pad_oe", int'(pad_oe), 0);
    chk("R1", "hsync", int'(hsync_o), 0);
    chk("R1", "vsync", int'(vsync_o), 0);
    chk("R1", "de", int'(de_o), 0);
    chk("R1", "field", int'(field_o), 0);
    chk("R1", "frame_start", int'(frame_start_o), 0);
    chk("R1", "pix", int'(pix_x) + int'(pix_y), 0);
    chk("R1", "start_delay", int'(start_delay), 0);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;

    // R8: enable release timing
    cfg_enable = 1;
    @(negedge clk);
    chk("R8", "oe after enable", int'(pad_oe), 1);
    chk("R6", "fs after enable", int'(frame_start_o), 1);
    repeat (60) @(negedge clk);

    // R9: change mid-field, old width holds until the wrap
    wait_fs();
    set_mode(0, 0, 6, 1, 2, 3, 3, 1, 1, 1);
    de_run(n);
    chk("R9", "de run before wrap", n, 4);
    wait_fs();
    de_run(n);
    chk("R9", "de run after wrap", n, 6);
    cfg_enable = 0;
    @(negedge clk);
    chk("R8", "oe after disable", int'(pad_oe), 0);

    // R3/R5: secondary interlaced with odd total, then secondary progressive
    set_mode(1, 1, 3, 1, 1, 1, 4, 1, 1, 2);
    cfg_hs_inv = 1; cfg_vs_inv = 1;
    cfg_enable = 1;
    repeat (200) @(negedge clk);
    cfg_enable = 0; @(negedge clk);
    // R7: force-high overrides inversion
    set_mode(1, 0, 3, 2, 2, 1, 3, 1, 2, 1);
    cfg_force_high = 1;
    cfg_enable = 1;
    repeat (150) @(negedge clk);
    cfg_force_high = 0;

    // random modes, some switched mid-field
    for (int i = 0; i < 14; i++) begin
      rand_mode();
      repeat (40 + $urandom % 200) @(negedge clk);
      if ((i % 4) == 3) begin
        cfg_enable = 0;
        repeat (2) @(negedge clk);
        cfg_enable = 1;
      end
    end

    // R10: delay derivation corners
    delay_case(0, 0, 600, 480, 30);
    delay_case(1, 1, 525, 480, 20);
    delay_case(1, 0, 1250, 480, 30);
    delay_case(1, 0, 20, 9, 0);
    delay_case(0, 1, 13, 6, 3);
    delay_case(0, 0, 40, 10, 30);
    delay_case(0, 0, 38, 10, 28);
    delay_case(1, 0, 30, 10, 3);

    cmp_on = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule